// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block controls the power-up of a line-fed switching converter. Its inputs are digital flags from analog comparators that are not part of this block. The flags report five conditions: the input is above the turn-on level, the input is below the turn-off level, the drop across the inrush-limiting resistor is below its bypass level, the inrush feature is strapped off, and the stop input is high. The block synchronises and debounces each flag. It then steps through four states: lockout, charging, soft start and run.

From that state the block drives several outputs. One closes the switch that shorts the inrush resistor. One holds the soft-start state discharged. One enables the PWM core. One powers the current-sense path. It also produces a soft-start ceiling as a digital count. The count rises one step at a programmable interval until it reaches full scale, and the sequencer then settles in the run state. Undervoltage lockout uses two separate thresholds, which gives it hysteresis. A stop request discharges the soft-start ramp completely, so every restart begins from zero.

Top module: `cvt_startup_seq`

## Requirements
- R1: After reset, state_o is 0 (lockout), bypass_o and pwm_en_o are low, ss_dis_o and sense_pwr_o are high, and ss_ceiling_o is 0.
- R2: Each raw flag passes through SYNC_STAGES flip-flops. The filtered flag takes a new value only after the synchronised sample has differed from it on DEB_LEN consecutive clocks. A pulse shorter than that has no effect on any output.
- R3: The sequencer stays in lockout until the filtered turn-on flag is high and the filtered turn-off flag is low. It then moves to charging (state_o = 1).
- R4: Outside lockout, the turn-on flag going low has no effect. The filtered turn-off flag returns the sequencer to lockout from any state on the next clock, with the bypass open, pwm_en_o low and the ceiling at 0.
- R5: The bypass switch closes only outside lockout, while the filtered drop flag is high and the inrush feature is enabled. Once closed it stays closed until lockout or until the inrush feature is disabled.
- R6: While the filtered inrush-disable flag is high, bypass_o stays low and sense_pwr_o is low, and soft start may begin without the drop flag.
- R7: Charging moves to soft start (state_o = 2) only when the stop flag is low and either the bypass is already closed or the inrush feature is disabled.
- R8: A filtered stop flag in soft start or run returns the sequencer to charging on the next clock, with ss_dis_o high and the ceiling cleared to 0 on the same edge.
- R9: In soft start the ceiling rises by exactly one every SS_STEP_CLKS clocks, counted from the edge that enters soft start, and saturates at 2^SS_WIDTH-1. The clock after it reaches full scale, the state becomes run (state_o = 3) and the ceiling holds.
- R10: ss_dis_o is high exactly in states 0 and 1, and pwm_en_o is high exactly in states 2 and 3. The state encoding is lockout=0, charging=1, soft start=2, run=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_on_i | input | 1 | Input voltage is above the turn-on level |
| below_off_i | input | 1 | Input voltage is below the turn-off level |
| drop_low_i | input | 1 | Drop across the inrush resistor is below the bypass level |
| inrush_off_i | input | 1 | Inrush feature is strapped off |
| stop_i | input | 1 | External stop (high stops the converter) |
| state_o | output | 2 | Sequencer state |
| bypass_o | output | 1 | Close the inrush-resistor bypass switch |
| ss_dis_o | output | 1 | Hold the soft-start state discharged |
| pwm_en_o | output | 1 | Enable the PWM core |
| sense_pwr_o | output | 1 | Power the inrush current-sense path |
| ss_ceiling_o | output | SS_WIDTH | Soft-start ceiling count |

## Verification
The bench aims at the following corner cases. Each has a distinct wrong behaviour that a defective design would show.

- A turn-on glitch one clock shorter than the debounce window must leave the sequencer in lockout. A filter that is one sample too eager would start charging.
- Letting the turn-on flag fall back while the turn-off flag stays low probes the hysteresis. A single-threshold design would drop back into lockout.
- Holding the charging state with no drop flag, and later asserting stop in the middle of a ramp, tests two rules. A design that ignored the bypass gate would start early. One that cleared the ceiling late would restart from a nonzero ceiling.
- A run with the inrush feature strapped off must reach soft start with the bypass open and the sense path unpowered.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

   typedef enum logic [1:0] {
      ST_LOCKOUT = 2'd0,
      ST_CHARGE  = 2'd1,
      ST_SOFT    = 2'd2,
      ST_RUN     = 2'd3
   } seq_state_e;

   localparam int FL_ON    = 0;
   localparam int FL_OFF   = 1;
   localparam int FL_DROP  = 2;
   localparam int FL_DIS   = 3;
   localparam int FL_STOP  = 4;
   localparam int N_FLAGS  = 5;

endpackage

// File: rtl/cvt_flag_filter.sv
module cvt_flag_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_LEN     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);

   localparam int CNT_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cvt_flag_filter: SYNC_STAGES must be at least 2");
   end
   if (DEB_LEN < 1) begin : g_bad_deb
      $error("cvt_flag_filter: DEB_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   if (DEB_LEN == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
         end else begin
            filt_q <= sync_out;
         end
      end
   end else begin : g_counted
      logic [CNT_W-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
         end else if (sync_out != filt_q) begin
            if (run_q == CNT_LAST) begin
               filt_q <= sync_out;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign filt_o = filt_q;

   // R2: an agreeing sample never changes the filtered value
   assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_out == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/cvt_ss_ramp.sv
module cvt_ss_ramp #(
   parameter int SS_WIDTH     = 8,
   parameter int SS_STEP_CLKS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                advance_i,
   input  logic                hold_i,
   output logic [SS_WIDTH-1:0] ceiling_o,
   output logic                full_o
);

   localparam logic [SS_WIDTH-1:0] CEIL_MAX = {SS_WIDTH{1'b1}};
   localparam int DIV_W = (SS_STEP_CLKS > 1) ? $clog2(SS_STEP_CLKS) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_STEP_CLKS - 1);

   if (SS_WIDTH < 1 || SS_WIDTH > 16) begin : g_bad_width
      $error("cvt_ss_ramp: SS_WIDTH out of range 1..16");
   end
   if (SS_STEP_CLKS < 1) begin : g_bad_step
      $error("cvt_ss_ramp: SS_STEP_CLKS must be at least 1");
   end

   logic [SS_WIDTH-1:0] ceil_q;
   logic                tick;

   if (SS_STEP_CLKS == 1) begin : g_every_clk
      assign tick = advance_i;
   end else begin : g_divided
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (advance_i) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
         end else begin
            div_q <= '0;
         end
      end
      assign tick = advance_i && (div_q == DIV_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ceil_q <= '0;
      end else if (advance_i) begin
         if (tick && ceil_q != CEIL_MAX) begin
            ceil_q <= ceil_q + 1'b1;
         end
      end else if (!hold_i) begin
         ceil_q <= '0;
      end
   end

   assign ceiling_o = ceil_q;
   assign full_o    = (ceil_q == CEIL_MAX);

   // R9: while ramping the ceiling moves by at most one step
   assert_ceiling_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      advance_i |=> (ceil_q == $past(ceil_q) || ceil_q == $past(ceil_q) + 1'b1));

   // R9: full scale is kept while ramping or holding
   assert_ceiling_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && (advance_i || hold_i)) |=> full_o);

endmodule

// File: rtl/cvt_seq_fsm.sv
module cvt_seq_fsm
   import cvt_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       on_i,
   input  logic       off_i,
   input  logic       drop_i,
   input  logic       dis_i,
   input  logic       stop_i,
   input  logic       ramp_full_i,
   output seq_state_e state_o,
   output seq_state_e state_nxt_o,
   output logic       bypass_o
);

   seq_state_e state_q;
   seq_state_e state_d;
   logic       byp_q;
   logic       byp_d;
   logic       ready_to_ramp;

   assign ready_to_ramp = !stop_i && (byp_q || dis_i);

   always_comb begin
      state_d = state_q;
      if (state_q == ST_LOCKOUT) begin
         if (on_i && !off_i) begin
            state_d = ST_CHARGE;
         end
      end else if (off_i) begin
         state_d = ST_LOCKOUT;
      end else begin
         unique case (state_q)
            ST_CHARGE: if (ready_to_ramp) state_d = ST_SOFT;
            ST_SOFT: begin
               if (stop_i) begin
                  state_d = ST_CHARGE;
               end else if (ramp_full_i) begin
                  state_d = ST_RUN;
               end
            end
            ST_RUN:    if (stop_i) state_d = ST_CHARGE;
            default:   state_d = ST_LOCKOUT;
         endcase
      end
   end

   assign byp_d = (state_q != ST_LOCKOUT) && !off_i && !dis_i && (byp_q || drop_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOCKOUT;
         byp_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         byp_q   <= byp_d;
      end
   end

   assign state_o     = state_q;
   assign state_nxt_o = state_d;
   assign bypass_o    = byp_q;

   // R3: lockout is left only with the turn-on flag
   assert_lockout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCKOUT && !on_i) |=> state_q == ST_LOCKOUT);

   // R4: turn-off flag forces lockout with the bypass open
   assert_uv_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_LOCKOUT && off_i) |=> (state_q == ST_LOCKOUT && !byp_q));

   // R7: no soft start while the bypass is open and the feature is enabled
   assert_no_early_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHARGE && !byp_q && !dis_i) |=> state_q != ST_SOFT);

   // R8: stop returns an active converter to charging
   assert_stop_recharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SOFT || state_q == ST_RUN) && stop_i && !off_i)
      |=> state_q == ST_CHARGE);

   // R6: disabled inrush feature keeps the bypass open
   assert_bypass_dis_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |=> !byp_q);

endmodule

// File: rtl/cvt_startup_seq.sv
module cvt_startup_seq
   import cvt_seq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DEB_LEN      = 8,
   parameter int SS_WIDTH     = 8,
   parameter int SS_STEP_CLKS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                above_on_i,
   input  logic                below_off_i,
   input  logic                drop_low_i,
   input  logic                inrush_off_i,
   input  logic                stop_i,
   output logic [1:0]          state_o,
   output logic                bypass_o,
   output logic                ss_dis_o,
   output logic                pwm_en_o,
   output logic                sense_pwr_o,
   output logic [SS_WIDTH-1:0] ss_ceiling_o
);

   logic [N_FLAGS-1:0] raw_flags;
   logic [N_FLAGS-1:0] flt_flags;
   seq_state_e         state;
   seq_state_e         state_nxt;
   logic               ramp_full;
   logic               ramp_adv;
   logic               ramp_hold;

   assign raw_flags[FL_ON]   = above_on_i;
   assign raw_flags[FL_OFF]  = below_off_i;
   assign raw_flags[FL_DROP] = drop_low_i;
   assign raw_flags[FL_DIS]  = inrush_off_i;
   assign raw_flags[FL_STOP] = stop_i;

   for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
      cvt_flag_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .DEB_LEN     (DEB_LEN)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_flags[gi]),
         .filt_o (flt_flags[gi])
      );
   end

   cvt_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .on_i        (flt_flags[FL_ON]),
      .off_i       (flt_flags[FL_OFF]),
      .drop_i      (flt_flags[FL_DROP]),
      .dis_i       (flt_flags[FL_DIS]),
      .stop_i      (flt_flags[FL_STOP]),
      .ramp_full_i (ramp_full),
      .state_o     (state),
      .state_nxt_o (state_nxt),
      .bypass_o    (bypass_o)
   );

   assign ramp_adv  = (state_nxt == ST_SOFT);
   assign ramp_hold = (state_nxt == ST_RUN);

   cvt_ss_ramp #(
      .SS_WIDTH     (SS_WIDTH),
      .SS_STEP_CLKS (SS_STEP_CLKS)
   ) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (ramp_adv),
      .hold_i    (ramp_hold),
      .ceiling_o (ss_ceiling_o),
      .full_o    (ramp_full)
   );

   assign state_o     = state;
   assign ss_dis_o    = (state == ST_LOCKOUT) || (state == ST_CHARGE);
   assign pwm_en_o    = (state == ST_SOFT) || (state == ST_RUN);
   assign sense_pwr_o = !flt_flags[FL_DIS];

   // R8: a discharged soft start always shows a zero ceiling
   assert_discharged_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ss_dis_o |-> (ss_ceiling_o == '0));

   // R9: run is only reached from a full-scale ramp
   assert_run_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RUN) |=> (state != ST_RUN || $past(ramp_full)));

endmodule

// File: tb/cvt_startup_seq_tb.sv
module cvt_startup_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC_ST    = 2;
   localparam int DEB        = 3;
   localparam int SW         = 4;
   localparam int STEP       = 2;
   localparam int CMAX       = (1 << SW) - 1;
   localparam int WD_LIMIT   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    raw = '0;   // 0 on, 1 off, 2 drop, 3 dis, 4 stop
   logic [1:0]    state_o;
   logic          bypass_o, ss_dis_o, pwm_en_o, sense_pwr_o;
   logic [SW-1:0] ss_ceiling_o;

   int    n_vec = 0;
   int    n_bad = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   cvt_startup_seq #(
      .SYNC_STAGES (SYNC_ST),
      .DEB_LEN     (DEB),
      .SS_WIDTH    (SW),
      .SS_STEP_CLKS(STEP)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .above_on_i   (raw[0]),
      .below_off_i  (raw[1]),
      .drop_low_i   (raw[2]),
      .inrush_off_i (raw[3]),
      .stop_i       (raw[4]),
      .state_o      (state_o),
      .bypass_o     (bypass_o),
      .ss_dis_o     (ss_dis_o),
      .pwm_en_o     (pwm_en_o),
      .sense_pwr_o  (sense_pwr_o),
      .ss_ceiling_o (ss_ceiling_o)
   );

   // behavioural reference model
   int m_s1[5], m_s2[5], m_f[5], m_run[5];
   int m_st = 0, m_byp = 0, m_ceil = 0, m_div = 0;

   always @(posedge clk) begin
      int nst, nbyp;
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
         end
         m_st = 0; m_byp = 0; m_ceil = 0; m_div = 0;
      end else begin
         // sequencing from current filtered flags
         nst = m_st;
         if (m_st == 0) begin
            if (m_f[0] == 1 && m_f[1] == 0) nst = 1;
         end else if (m_f[1] == 1) begin
            nst = 0;
         end else if (m_st == 1) begin
            if (m_f[4] == 0 && (m_byp == 1 || m_f[3] == 1)) nst = 2;
         end else if (m_st == 2) begin
            if (m_f[4] == 1) nst = 1;
            else if (m_ceil == CMAX) nst = 3;
         end else begin
            if (m_f[4] == 1) nst = 1;
         end
         nbyp = (m_st != 0 && m_f[1] == 0 && m_f[3] == 0 &&
                 (m_byp == 1 || m_f[2] == 1)) ? 1 : 0;
         if (nst == 2) begin
            if (m_div == STEP - 1) begin
               m_div = 0;
               if (m_ceil < CMAX) m_ceil++;
            end else begin
               m_div++;
            end
         end else if (nst == 3) begin
            m_div = 0;
         end else begin
            m_div = 0; m_ceil = 0;
         end
         m_st = nst; m_byp = nbyp;
         for (int i = 0; i < 5; i++) begin
            if (m_s2[i] != m_f[i]) begin
               if (m_run[i] == DEB - 1) begin
                  m_f[i] = m_s2[i]; m_run[i] = 0;
               end else begin
                  m_run[i]++;
               end
            end else begin
               m_run[i] = 0;
            end
            m_s2[i] = m_s1[i];
            m_s1[i] = int'(raw[i]);
         end
      end
   end

   task automatic cmp(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp(cur_req, int'(state_o), m_st);
         cmp("R5", int'(bypass_o), m_byp);
         cmp("R10", int'(ss_dis_o), (m_st < 2) ? 1 : 0);
         cmp("R10", int'(pwm_en_o), (m_st >= 2) ? 1 : 0);
         cmp("R6", int'(sense_pwr_o), (m_f[3] == 0) ? 1 : 0);
         cmp("R9", int'(ss_ceiling_o), m_ceil);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == WD_LIMIT && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      cmp("R1", int'(state_o), 0);
      cmp("R1", int'(bypass_o), 0);
      cmp("R1", int'(pwm_en_o), 0);
      cmp("R1", int'(ss_dis_o), 1);
      cmp("R1", int'(sense_pwr_o), 1);
      cmp("R1", int'(ss_ceiling_o), 0);

      // R2: turn-on pulse one clock shorter than the window
      cur_req = "R2";
      raw[0] = 1'b1; idle(DEB - 1); raw[0] = 1'b0;
      idle(12);
      cmp("R2", int'(state_o), 0);

      // R3: sustained turn-on leaves lockout
      cur_req = "R3";
      raw[0] = 1'b1; idle(12);
      cmp("R3", int'(state_o), 1);

      // R4: input sags between thresholds, stays out of lockout
      cur_req = "R4";
      raw[0] = 1'b0; idle(12);
      cmp("R4", int'(state_o), 1);

      // R7: no drop flag, still charging
      cur_req = "R7";
      idle(10);
      cmp("R7", int'(pwm_en_o), 0);
      cmp("R7", int'(state_o), 1);

      // R5: drop below bypass level closes switch, then ramp
      cur_req = "R5";
      raw[2] = 1'b1; idle(8);
      cmp("R5", int'(bypass_o), 1);
      raw[2] = 1'b0; idle(8);
      cmp("R5", int'(bypass_o), 1);

      // R9: ramp to full scale and run
      cur_req = "R9";
      idle(CMAX * STEP + 10);
      cmp("R9", int'(state_o), 3);
      cmp("R9", int'(ss_ceiling_o), CMAX);

      // R8: stop from run
      cur_req = "R8";
      raw[4] = 1'b1; idle(10);
      cmp("R8", int'(state_o), 1);
      cmp("R8", int'(ss_ceiling_o), 0);
      cmp("R8", int'(ss_dis_o), 1);
      raw[4] = 1'b0; idle(14);
      cmp("R8", int'(state_o), 2);
      // stop mid-ramp
      raw[4] = 1'b1; idle(10);
      cmp("R8", int'(ss_ceiling_o), 0);
      raw[4] = 1'b0; idle(CMAX * STEP + 12);

      // R4: turn-off flag forces lockout from run
      cur_req = "R4";
      raw[1] = 1'b1; idle(10);
      cmp("R4", int'(state_o), 0);
      cmp("R4", int'(bypass_o), 0);
      cmp("R4", int'(ss_ceiling_o), 0);

      // R6: inrush feature strapped off
      cur_req = "R6";
      raw[1] = 1'b0; raw[3] = 1'b1; idle(10);
      raw[0] = 1'b1; idle(14);
      cmp("R6", int'(sense_pwr_o), 0);
      cmp("R6", int'(state_o), 2);
      cmp("R6", int'(bypass_o), 0);
      raw[2] = 1'b1; idle(10);
      cmp("R6", int'(bypass_o), 0);
      cur_req = "R10";
      idle(CMAX * STEP + 10);
      cmp("R10", int'(pwm_en_o), 1);
      cmp("R10", int'(ss_dis_o), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule